// File: doc/BRIEF.md
# Xon/Xoff Software Flow Engine

This block handles in-band flow control for a single serial channel. Every byte that leaves the receive deserializer passes through it. When a byte matches the programmed stop character, the local transmitter is told to pause. When a byte matches the programmed go character, the transmitter is told to resume. In pair mode, a stop or go event needs two consecutive bytes that match a programmed two-byte sequence. Bytes that are consumed as control characters never reach the receive FIFO. All other bytes reach it unchanged and in their original order.

The block also watches the fill level of the receive FIFO and asks the transmitter to send the stop character(s) or the go character(s) to the far end. The thresholds come from a four-entry table selected by a trigger setting. The transmitter is expected to send a requested control character ahead of queued payload at its next character boundary, whether or not it is paused. Both byte streams use valid/ready. A transfer happens on a rising clock edge where valid and ready are both high. Once valid is raised, it and the data stay unchanged until the transfer. The receive input takes a new byte only when the single output slot is free or is being emptied in the same cycle, and when no replayed byte is waiting.

Top module: `swf_engine`

## Requirements
- R1: After reset, fifo_valid, ins_valid, xoff_flag and irq are 0, tx_allow is 1, and all four match characters are 0x00.
- R2: A write with wr_en high loads wr_data into the character chosen by wr_sel: 0 = go-first, 1 = go-second, 2 = stop-first, 3 = stop-second.
- R3: With sw_en=1 and dbl_mode=0, an accepted byte equal to stop-first drives tx_allow low from the next cycle and is not forwarded. The stop comparison wins when both characters are equal.
- R4: With sw_en=1 and dbl_mode=0, an accepted byte equal to go-first (and not equal to stop-first) drives tx_allow high, clears xoff_flag, and is not forwarded.
- R5: Bytes that do not match are forwarded in arrival order. With sw_en=0, every byte is forwarded and tx_allow does not change.
- R6: With dbl_mode=1, stop-first followed by stop-second suspends, and go-first followed by go-second resumes. Neither byte of a matching pair is forwarded.
- R7: With dbl_mode=1, if a held first byte is followed by a byte that does not complete the pair, the held byte is forwarded first. The new byte is then either forwarded after it or held as a new first byte, if it matches one.
- R8: A stop match sets xoff_flag. A go match clears it. irq equals xoff_flag gated by int_en.
- R9: With auto_en=1, ins_valid rises with stop-first once fifo_level reaches 4, 8, 12 or 14, for trig_sel 0, 1, 2 or 3 respectively.
- R10: After a stop request, a go request (go-first) is raised once fifo_level falls to 1, 4, 8 or 10, for trig_sel 0 to 3. Each request is made only once per threshold crossing.
- R11: In dbl_mode, a request presents the first character and then, after it is accepted, the second character.
- R12: Requests are raised and held whether tx_allow is high or low. ins_data stays stable while ins_valid is high and ins_ready is low.
- R13: While fifo_valid is high and fifo_ready is low, fifo_data stays stable and rx_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_en | input | 1 | Enable receive-side matching |
| dbl_mode | input | 1 | 1 = two-byte sequences, 0 = single bytes |
| auto_en | input | 1 | Enable level-driven stop/go requests |
| trig_sel | input | 2 | Threshold table selection |
| int_en | input | 1 | Gate for irq |
| wr_en | input | 1 | Character register write strobe |
| wr_sel | input | 2 | Character register select |
| wr_data | input | DW | Character register write data |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | DW | Received byte |
| rx_ready | output | 1 | Block can take a received byte |
| fifo_valid | output | 1 | Filtered byte valid |
| fifo_data | output | DW | Filtered byte to receive FIFO |
| fifo_ready | input | 1 | Receive FIFO can take a byte |
| fifo_level | input | LW | Current receive FIFO occupancy |
| ins_valid | output | 1 | Control character waiting for the transmitter |
| ins_data | output | DW | Control character to send |
| ins_ready | input | 1 | Transmitter takes the control character |
| tx_allow | output | 1 | Transmitter may start payload characters |
| xoff_flag | output | 1 | Stop received status |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted hold register shows up at fifo_data within one or two cycles of the next received byte, as a missing, duplicated or reordered byte. A corrupted suspend state shows up on tx_allow one cycle after the matching byte is accepted. A wrong sent-state bit shows up at ins_valid within two cycles of the next level change: either a repeated request or a missing one. A lost pair stage shows up as a second-character request that is missing or wrong after the first one is accepted.

// File: rtl/swf_pkg.sv
package swf_pkg;
  typedef enum logic {K_GO = 1'b0, K_STOP = 1'b1} ctl_kind_t;

  function automatic logic [7:0] stop_at(input logic [1:0] t);
    case (t)
      2'd0:    return 8'd4;
      2'd1:    return 8'd8;
      2'd2:    return 8'd12;
      default: return 8'd14;
    endcase
  endfunction

  function automatic logic [7:0] go_at(input logic [1:0] t);
    case (t)
      2'd0:    return 8'd1;
      2'd1:    return 8'd4;
      2'd2:    return 8'd8;
      default: return 8'd10;
    endcase
  endfunction
endpackage

// File: rtl/swf_regs.sv
module swf_regs #(
  parameter int DW = 8,
  parameter int NCH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] go1,
  output logic [DW-1:0] go2,
  output logic [DW-1:0] stop1,
  output logic [DW-1:0] stop2
);
  logic [DW-1:0] chr [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_chr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                chr[g] <= '0;
      else if (wr_en && (int'(wr_sel) == g))     chr[g] <= wr_data;
    end
  end

  assign go1   = chr[0];
  assign go2   = chr[1];
  assign stop1 = chr[2];
  assign stop2 = chr[3];
endmodule

// File: rtl/swf_matcher.sv
module swf_matcher
  import swf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_en,
  input  logic          dbl_mode,
  input  logic [DW-1:0] go1,
  input  logic [DW-1:0] go2,
  input  logic [DW-1:0] stop1,
  input  logic [DW-1:0] stop2,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          fifo_valid,
  output logic [DW-1:0] fifo_data,
  input  logic          fifo_ready,
  output logic          hit_stop,
  output logic          hit_go
);
  logic          out_v, rp_v, hold_v;
  logic [DW-1:0] out_d, rp_d, hold_d;
  ctl_kind_t     hold_k, new_k;
  logic          out_free, fire;
  logic          is_s1, is_g1, pair_done;
  logic          fwd_new, fwd_held, hold_set, hold_clr;

  assign out_free  = !out_v || fifo_ready;
  assign rx_ready  = out_free && !rp_v;
  assign fire      = rx_valid && rx_ready;
  assign is_s1     = (rx_data == stop1);
  assign is_g1     = (rx_data == go1);
  assign pair_done = hold_v && ((hold_k == K_STOP) ? (rx_data == stop2) : (rx_data == go2));

  always_comb begin
    fwd_new  = 1'b0;
    fwd_held = 1'b0;
    hold_set = 1'b0;
    hold_clr = 1'b0;
    new_k    = K_STOP;
    hit_stop = 1'b0;
    hit_go   = 1'b0;
    if (fire) begin
      if (!sw_en || !dbl_mode) begin
        // a byte held from an earlier pair-mode setting is released first
        fwd_held = hold_v;
        hold_clr = hold_v;
        if (!sw_en)     fwd_new  = 1'b1;
        else if (is_s1) hit_stop = 1'b1;
        else if (is_g1) hit_go   = 1'b1;
        else            fwd_new  = 1'b1;
      end else if (pair_done) begin
        hold_clr = 1'b1;
        hit_stop = (hold_k == K_STOP);
        hit_go   = (hold_k == K_GO);
      end else begin
        fwd_held = hold_v;
        hold_clr = hold_v;
        if (is_s1) begin
          hold_set = 1'b1;
          new_k    = K_STOP;
        end else if (is_g1) begin
          hold_set = 1'b1;
          new_k    = K_GO;
        end else begin
          fwd_new = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v  <= 1'b0;
      out_d  <= '0;
      rp_v   <= 1'b0;
      rp_d   <= '0;
      hold_v <= 1'b0;
      hold_d <= '0;
      hold_k <= K_STOP;
    end else begin
      if (out_free) out_v <= 1'b0;
      if (rp_v && out_free) begin
        out_v <= 1'b1;
        out_d <= rp_d;
        rp_v  <= 1'b0;
      end else if (fwd_held || fwd_new) begin
        out_v <= 1'b1;
        out_d <= fwd_held ? hold_d : rx_data;
        if (fwd_held && fwd_new) begin
          rp_v <= 1'b1;
          rp_d <= rx_data;
        end
      end
      if (hold_clr) hold_v <= 1'b0;
      if (hold_set) begin
        hold_v <= 1'b1;
        hold_d <= rx_data;
        hold_k <= new_k;
      end
    end
  end

  assign fifo_valid = out_v;
  assign fifo_data  = out_d;
endmodule

// File: rtl/swf_autosend.sv
module swf_autosend
  import swf_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          auto_en,
  input  logic          dbl_mode,
  input  logic [1:0]    trig_sel,
  input  logic [LW-1:0] fifo_level,
  input  logic [DW-1:0] go1,
  input  logic [DW-1:0] go2,
  input  logic [DW-1:0] stop1,
  input  logic [DW-1:0] stop2,
  output logic          ins_valid,
  output logic [DW-1:0] ins_data,
  input  logic          ins_ready
);
  logic          q_v, q_two, q_stage, sent;
  logic [DW-1:0] q_d, q_next;
  logic          lvl_hi, lvl_lo;

  assign lvl_hi = int'(fifo_level) >= int'(stop_at(trig_sel));
  assign lvl_lo = int'(fifo_level) <= int'(go_at(trig_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_v     <= 1'b0;
      q_two   <= 1'b0;
      q_stage <= 1'b0;
      q_d     <= '0;
      q_next  <= '0;
      sent    <= 1'b0;
    end else begin
      if (!auto_en) begin
        sent <= 1'b0;
      end else if (!q_v) begin
        if (!sent && lvl_hi) begin
          q_v     <= 1'b1;
          q_two   <= dbl_mode;
          q_stage <= 1'b0;
          q_d     <= stop1;
          q_next  <= stop2;
          sent    <= 1'b1;
        end else if (sent && lvl_lo) begin
          q_v     <= 1'b1;
          q_two   <= dbl_mode;
          q_stage <= 1'b0;
          q_d     <= go1;
          q_next  <= go2;
          sent    <= 1'b0;
        end
      end
      if (q_v && ins_ready) begin
        if (q_two && !q_stage) begin
          q_stage <= 1'b1;
          q_d     <= q_next;
        end else begin
          q_v <= 1'b0;
        end
      end
    end
  end

  assign ins_valid = q_v;
  assign ins_data  = q_d;
endmodule

// File: rtl/swf_engine.sv
module swf_engine
  import swf_pkg::*;
#(
  parameter int DW = 8,
  parameter int FIFO_DEPTH = 16,
  localparam int LW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_en,
  input  logic          dbl_mode,
  input  logic          auto_en,
  input  logic [1:0]    trig_sel,
  input  logic          int_en,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          fifo_valid,
  output logic [DW-1:0] fifo_data,
  input  logic          fifo_ready,
  input  logic [LW-1:0] fifo_level,
  output logic          ins_valid,
  output logic [DW-1:0] ins_data,
  input  logic          ins_ready,
  output logic          tx_allow,
  output logic          xoff_flag,
  output logic          irq
);
  logic [DW-1:0] w_go1, w_go2, w_stop1, w_stop2;
  logic          hit_stop, hit_go;
  logic          susp, flag_q;

  swf_regs #(.DW(DW), .NCH(4)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .go1(w_go1), .go2(w_go2), .stop1(w_stop1), .stop2(w_stop2)
  );

  swf_matcher #(.DW(DW)) u_match (
    .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .dbl_mode(dbl_mode),
    .go1(w_go1), .go2(w_go2), .stop1(w_stop1), .stop2(w_stop2),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_ready(fifo_ready),
    .hit_stop(hit_stop), .hit_go(hit_go)
  );

  swf_autosend #(.DW(DW), .LW(LW)) u_auto (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .dbl_mode(dbl_mode),
    .trig_sel(trig_sel), .fifo_level(fifo_level),
    .go1(w_go1), .go2(w_go2), .stop1(w_stop1), .stop2(w_stop2),
    .ins_valid(ins_valid), .ins_data(ins_data), .ins_ready(ins_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      susp   <= 1'b0;
      flag_q <= 1'b0;
    end else if (hit_stop) begin
      susp   <= 1'b1;
      flag_q <= 1'b1;
    end else if (hit_go) begin
      susp   <= 1'b0;
      flag_q <= 1'b0;
    end
  end

  assign tx_allow  = !susp;
  assign xoff_flag = flag_q;
  assign irq       = flag_q && int_en;
endmodule

// File: rtl/swf_engine_chk.sv
module swf_engine_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_en,
  input logic          dbl_mode,
  input logic          auto_en,
  input logic          rx_valid,
  input logic [DW-1:0] rx_data,
  input logic          rx_ready,
  input logic          fifo_valid,
  input logic [DW-1:0] fifo_data,
  input logic          fifo_ready,
  input logic          ins_valid,
  input logic [DW-1:0] ins_data,
  input logic          ins_ready,
  input logic          tx_allow,
  input logic          xoff_flag,
  input logic [DW-1:0] stop1
);
  a_r13_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_valid && !fifo_ready |=> fifo_valid && $stable(fifo_data));

  a_r12_ins_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid && !ins_ready |=> ins_valid && $stable(ins_data));

  a_r3_stop_match: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready && sw_en && !dbl_mode && (rx_data == stop1) |=> !tx_allow);

  a_r8_flag_with_pause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xoff_flag) |-> !tx_allow);

  a_r9_request_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ins_valid) |-> $past(auto_en));
endmodule

bind swf_engine swf_engine_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .dbl_mode(dbl_mode), .auto_en(auto_en),
  .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
  .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_ready(fifo_ready),
  .ins_valid(ins_valid), .ins_data(ins_data), .ins_ready(ins_ready),
  .tx_allow(tx_allow), .xoff_flag(xoff_flag), .stop1(w_stop1)
);

// File: tb/test_swf_engine.sv
module test_swf_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_en = 1'b0, dbl_mode = 1'b0, auto_en = 1'b0, int_en = 1'b0;
  logic [1:0] trig_sel = 2'd0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'd0;
  logic       rx_ready;
  logic       fifo_valid;
  logic [7:0] fifo_data;
  logic       fifo_ready = 1'b1;
  logic [4:0] fifo_level = 5'd0;
  logic       ins_valid;
  logic [7:0] ins_data;
  logic       ins_ready = 1'b0;
  logic       tx_allow, xoff_flag, irq;

  int n_chk = 0, n_fail = 0, gcnt = 0;
  logic [7:0] last_got = 8'd0;

  always #10 clk = ~clk;

  swf_engine i_swf_engine (.*);

  always @(negedge clk) begin
    if (fifo_valid && fifo_ready) begin
      last_got = fifo_data;
      gcnt++;
    end
  end

  typedef struct packed {
    logic       dbl;
    logic [7:0] b;
    logic       allow;
    logic [7:0] cnt;
    logic [7:0] last;
  } vec_t;

  // go1=11 go2=12 stop1=13 stop2=14; R3 R4 R5 R6 R7 exercised
  localparam vec_t VEC [17] = '{
    '{1'b0, 8'h41, 1'b1, 8'd1, 8'h41},
    '{1'b0, 8'h13, 1'b0, 8'd1, 8'h41},
    '{1'b0, 8'h42, 1'b0, 8'd2, 8'h42},
    '{1'b0, 8'h11, 1'b1, 8'd2, 8'h42},
    '{1'b0, 8'h12, 1'b1, 8'd3, 8'h12},
    '{1'b1, 8'h13, 1'b1, 8'd3, 8'h12},
    '{1'b1, 8'h14, 1'b0, 8'd3, 8'h12},
    '{1'b1, 8'h11, 1'b0, 8'd3, 8'h12},
    '{1'b1, 8'h43, 1'b0, 8'd5, 8'h43},
    '{1'b1, 8'h11, 1'b0, 8'd5, 8'h43},
    '{1'b1, 8'h11, 1'b0, 8'd6, 8'h11},
    '{1'b1, 8'h12, 1'b1, 8'd6, 8'h11},
    '{1'b1, 8'h13, 1'b1, 8'd6, 8'h11},
    '{1'b1, 8'h13, 1'b1, 8'd7, 8'h13},
    '{1'b1, 8'h14, 1'b0, 8'd7, 8'h13},
    '{1'b1, 8'h11, 1'b0, 8'd7, 8'h13},
    '{1'b1, 8'h12, 1'b1, 8'd7, 8'h13}
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
    idle(3);
  endtask

  task automatic wreg(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic take_ins();
    @(negedge clk);
    ins_ready = 1'b1;
    @(negedge clk);
    ins_ready = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int base;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check(!fifo_valid && !ins_valid && !xoff_flag && !irq, "R1 outputs idle",
          {fifo_valid, ins_valid, xoff_flag, irq}, 0);
    check(tx_allow, "R1 tx_allow", tx_allow, 1);

    // R1/R2: stop-first resets to 0x00, so a zero byte is a stop match
    sw_en = 1'b1;
    send(8'h00);
    check(!tx_allow && gcnt == 0, "R2 zero stop char after reset", {tx_allow, 8'(gcnt)}, 0);

    wreg(2'd0, 8'h11); wreg(2'd1, 8'h12); wreg(2'd2, 8'h13); wreg(2'd3, 8'h14);
    send(8'h11);
    check(tx_allow && gcnt == 0, "R2 written go char resumes", {tx_allow, 8'(gcnt)}, 9'h100);

    // vector table
    base = gcnt;
    for (int i = 0; i < 17; i++) begin
      dbl_mode = VEC[i].dbl;
      send(VEC[i].b);
      check(tx_allow == VEC[i].allow, $sformatf("R3/R4/R6 table %0d tx_allow", i),
            tx_allow, VEC[i].allow);
      check(gcnt - base == int'(VEC[i].cnt), $sformatf("R5/R7 table %0d count", i),
            gcnt - base, VEC[i].cnt);
      check(last_got == VEC[i].last, $sformatf("R5/R7 table %0d last byte", i),
            last_got, VEC[i].last);
    end

    // R8 flag and interrupt gating
    dbl_mode = 1'b0;
    int_en = 1'b0;
    send(8'h13);
    check(xoff_flag && !irq, "R8 flag set irq masked", {xoff_flag, irq}, 2'b10);
    int_en = 1'b1;
    idle(1);
    check(irq, "R8 irq enabled", irq, 1);
    send(8'h11);
    check(!xoff_flag && !irq, "R8 go clears flag", {xoff_flag, irq}, 0);

    // R5 matching disabled
    sw_en = 1'b0;
    base = gcnt;
    send(8'h13);
    check(gcnt == base + 1 && last_got == 8'h13 && tx_allow, "R5 bypass when disabled",
          last_got, 8'h13);
    sw_en = 1'b1;

    // R13 back-pressure
    fifo_ready = 1'b0;
    base = gcnt;
    send(8'h55);
    check(fifo_valid && fifo_data == 8'h55, "R13 held output", fifo_data, 8'h55);
    check(!rx_ready && gcnt == base, "R13 input stalled", rx_ready, 0);
    fifo_ready = 1'b1;
    idle(2);
    check(gcnt == base + 1 && last_got == 8'h55, "R13 released", last_got, 8'h55);

    // R9 to R12 automatic requests, while paused
    send(8'h13);
    auto_en = 1'b1; trig_sel = 2'd1; fifo_level = 5'd7;
    idle(3);
    check(!ins_valid, "R9 below threshold", ins_valid, 0);
    fifo_level = 5'd8;
    idle(3);
    check(ins_valid && ins_data == 8'h13 && !tx_allow, "R9 R12 stop request while paused",
          ins_data, 8'h13);
    idle(2);
    check(ins_valid && ins_data == 8'h13, "R12 request held", ins_data, 8'h13);
    take_ins();
    check(!ins_valid, "R10 request done", ins_valid, 0);
    idle(3);
    check(!ins_valid, "R10 once per crossing", ins_valid, 0);
    fifo_level = 5'd5;
    idle(3);
    check(!ins_valid, "R10 above go level", ins_valid, 0);
    fifo_level = 5'd4;
    idle(3);
    check(ins_valid && ins_data == 8'h11, "R10 go request", ins_data, 8'h11);
    take_ins();
    check(!ins_valid, "R10 go done", ins_valid, 0);

    // R11 pair request
    dbl_mode = 1'b1;
    fifo_level = 5'd8;
    idle(3);
    check(ins_valid && ins_data == 8'h13, "R11 first char", ins_data, 8'h13);
    take_ins();
    check(ins_valid && ins_data == 8'h14, "R11 second char", ins_data, 8'h14);
    take_ins();
    check(!ins_valid, "R11 pair done", ins_valid, 0);

    // R9 other trigger: level 14 with trig 3 after go
    trig_sel = 2'd3; fifo_level = 5'd10;
    idle(3);
    take_ins(); take_ins();
    fifo_level = 5'd13;
    idle(3);
    check(!ins_valid, "R9 trig3 below", ins_valid, 0);
    fifo_level = 5'd14;
    idle(3);
    check(ins_valid && ins_data == 8'h13, "R9 trig3 at 14", ins_data, 8'h13);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule